// File: doc/BRIEF.md
# Dictionary-Order Bit Sequence Comparator

This block compares two bit sequences that may have different lengths. It orders them as words in a dictionary, not as binary numbers. Each operand width is a parameter fixed at elaboration. The block has no clock and no state. From the current inputs it produces six flags: equal, not-equal, less, less-or-equal, greater and greater-or-equal.

The comparison starts at the leftmost bit, which is the most significant index (width-1) of each operand. It moves right one position at a time. The first position where the two bits differ decides the order: the operand with 0 at that position is the lesser one. If one operand runs out while all compared bits match, the shorter operand is the lesser one, and the extra bits of the longer operand take no part. This suits key ordering, prefix matching and sorting networks whose keys have fixed but unequal lengths.

Top module: `lexcmp_top`

## Requirements
- R1: The leftmost pair, a[WA-1] against b[WB-1], has the highest priority. If those two bits differ, the result follows them whatever the bits to their right hold.
- R2: At the first differing position, the operand holding 0 is the lesser one: lt is 1 when a holds 0 and b holds 1 there.
- R3: If all min(WA,WB) leftmost positions match, the shorter operand is the lesser one. The trailing bits of the longer operand (its lowest |WA-WB| indices) have no effect on any output.
- R4: When WA differs from WB, eq is 0 and ne is 1 for every input value.
- R5: When WA equals WB, eq is 1 exactly when every bit of a equals the bit of b at the same index, and ne is always the inverse of eq.
- R6: gt is 1 exactly when b is less than a under the same ordering rules, with the length rule applied to b against a.
- R7: ge is always the inverse of lt, and le is always the inverse of gt.
- R8: Exactly one of lt, eq and gt is 1 for every input value.
- R9: When the lengths are equal and all bits match, both lt and gt are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WA | First operand; index WA-1 is the leftmost element |
| b | input | WB | Second operand; index WB-1 is the leftmost element |
| eq | output | 1 | Operands have the same length and the same bits |
| ne | output | 1 | Inverse of eq |
| lt | output | 1 | a orders before b |
| le | output | 1 | a does not order after b |
| gt | output | 1 | a orders after b |
| ge | output | 1 | a does not order before b |

## Verification
The bench builds three copies of the block, with widths 5 against 3, 4 against 4, and 2 against 6, and drives every input combination of each. The 5/3 copy puts the longer operand on a, and the 2/6 copy puts it on b. Between them they exercise the length tie-break in both directions and show that trailing bits are ignored on either side. The 4/4 copy is the only one in which eq can be 1, so it covers the equal-length equality path and the all-match case where neither lt nor gt is set.

// File: rtl/lexcmp_pkg.sv
package lexcmp_pkg;

  // Result flags, in output order.
  typedef struct packed {
    logic eq;
    logic ne;
    logic lt;
    logic le;
    logic gt;
    logic ge;
  } cmp_flags_t;

  // Number of positions that take part in the element walk.
  function automatic int common_len(input int wa, input int wb);
    return (wa < wb) ? wa : wb;
  endfunction

  // Seed at the far end of the less-than chain: the length ordering.
  function automatic logic len_less(input int wx, input int wy);
    return (wx < wy) ? 1'b1 : 1'b0;
  endfunction

  // Build all six flags from the two directed less-than results and equality.
  function automatic cmp_flags_t make_flags(input logic x_lt_y, input logic y_lt_x,
                                            input logic same);
    cmp_flags_t f;
    f.eq = same;
    f.ne = ~same;
    f.lt = x_lt_y;
    f.ge = ~x_lt_y;
    f.gt = y_lt_x;
    f.le = ~y_lt_x;
    return f;
  endfunction

endpackage

// File: rtl/lexcmp_chain.sv
// Ripple less-than over N aligned positions; index N-1 is leftmost.
module lexcmp_chain #(
  parameter int  N    = 3,
  parameter logic SEED = 1'b0
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic         x_lt_y,
  output logic         any_diff
);

  // c[k] is the verdict decided by positions below k (toward the right).
  logic [N:0] c;
  logic [N-1:0] pos_diff;

  assign c[0] = SEED;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_stage
      assign pos_diff[k] = x[k] ^ y[k];
      // A differing pair overrides everything to its right.
      assign c[k+1] = pos_diff[k] ? y[k] : c[k];
    end
  endgenerate

  assign x_lt_y   = c[N];
  assign any_diff = |pos_diff;

  always_comb begin
    // R1
    if (x[N-1] != y[N-1])
      leftmost_wins_chk: assert (x_lt_y == y[N-1])
        else $error("leftmost pair did not decide");
    // R3
    if (!any_diff)
      seed_pass_chk: assert (x_lt_y == SEED)
        else $error("matching prefix did not pass the length seed");
  end

endmodule

// File: rtl/lexcmp_equal.sv
// Equality over the aligned prefix, forced low when lengths differ.
module lexcmp_equal #(
  parameter int N        = 3,
  parameter bit SAME_LEN = 1'b0
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic         same
);

  logic [N-1:0] bit_match;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_xnor
      assign bit_match[k] = ~(x[k] ^ y[k]);
    end
    if (SAME_LEN) begin : g_len_eq
      assign same = &bit_match;
    end else begin : g_len_ne
      assign same = 1'b0 & (&bit_match);
    end
  endgenerate

endmodule

// File: rtl/lexcmp_top.sv
module lexcmp_top
  import lexcmp_pkg::*;
#(
  parameter int WA = 5,
  parameter int WB = 3
) (
  input  logic [WA-1:0] a,
  input  logic [WB-1:0] b,
  output logic          eq,
  output logic          ne,
  output logic          lt,
  output logic          le,
  output logic          gt,
  output logic          ge
);

  localparam int   N       = common_len(WA, WB);
  localparam logic SEED_AB = len_less(WA, WB);
  localparam logic SEED_BA = len_less(WB, WA);
  localparam bit   SAMEL   = (WA == WB);

  // Leftmost-aligned heads that take part in the walk.
  logic [N-1:0] a_head, b_head;
  assign a_head = a[WA-1 -: N];
  assign b_head = b[WB-1 -: N];

  logic a_lt_b, b_lt_a, diff_ab, diff_ba, heads_same;
  cmp_flags_t flags;

  lexcmp_chain #(.N(N), .SEED(SEED_AB)) u_ab (
    .x(a_head), .y(b_head), .x_lt_y(a_lt_b), .any_diff(diff_ab)
  );

  lexcmp_chain #(.N(N), .SEED(SEED_BA)) u_ba (
    .x(b_head), .y(a_head), .x_lt_y(b_lt_a), .any_diff(diff_ba)
  );

  lexcmp_equal #(.N(N), .SAME_LEN(SAMEL)) u_eq (
    .x(a_head), .y(b_head), .same(heads_same)
  );

  assign flags = make_flags(a_lt_b, b_lt_a, heads_same);
  assign eq = flags.eq;
  assign ne = flags.ne;
  assign lt = flags.lt;
  assign le = flags.le;
  assign gt = flags.gt;
  assign ge = flags.ge;

  always_comb begin
    // R8
    trichotomy_chk: assert ($countones({a_lt_b, heads_same, b_lt_a}) == 1)
      else $error("lt/eq/gt not exactly one");
    // R4
    if (!SAMEL)
      len_mismatch_chk: assert (!heads_same)
        else $error("unequal lengths reported equal");
    // R9
    if (SAMEL && !diff_ab)
      full_match_chk: assert (heads_same && !a_lt_b && !b_lt_a)
        else $error("identical operands not equal");
  end

  generate
    if (WA > WB) begin : g_a_tail
      logic [WA-WB-1:0] a_tail;
      assign a_tail = a[WA-WB-1:0];
      always_comb begin
        // R3
        if (!diff_ba)
          a_tail_ignored_chk: assert (b_lt_a && !a_lt_b)
            else $error("longer a with matching prefix not greater, tail %b", a_tail);
      end
    end else if (WB > WA) begin : g_b_tail
      logic [WB-WA-1:0] b_tail;
      assign b_tail = b[WB-WA-1:0];
      always_comb begin
        // R3
        if (!diff_ab)
          b_tail_ignored_chk: assert (a_lt_b && !b_lt_a)
            else $error("longer b with matching prefix not greater, tail %b", b_tail);
      end
    end
  endgenerate

endmodule

// File: tb/sim_lexcmp_top.sv
module sim_lexcmp_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  localparam int A0 = 5, B0 = 3;
  localparam int A1 = 4, B1 = 4;
  localparam int A2 = 2, B2 = 6;

  logic [A0-1:0] a0 = '0;  logic [B0-1:0] b0 = '0;
  logic [A1-1:0] a1 = '0;  logic [B1-1:0] b1 = '0;
  logic [A2-1:0] a2 = '0;  logic [B2-1:0] b2 = '0;
  logic [5:0] f0, f1, f2;   // {eq,ne,lt,le,gt,ge}

  lexcmp_top #(.WA(A0), .WB(B0)) u0 (.a(a0), .b(b0),
    .eq(f0[5]), .ne(f0[4]), .lt(f0[3]), .le(f0[2]), .gt(f0[1]), .ge(f0[0]));
  lexcmp_top #(.WA(A1), .WB(B1)) u1 (.a(a1), .b(b1),
    .eq(f1[5]), .ne(f1[4]), .lt(f1[3]), .le(f1[2]), .gt(f1[1]), .ge(f1[0]));
  lexcmp_top #(.WA(A2), .WB(B2)) u2 (.a(a2), .b(b2),
    .eq(f2[5]), .ne(f2[4]), .lt(f2[3]), .le(f2[2]), .gt(f2[1]), .ge(f2[0]));

  typedef struct {
    int         id;
    logic [7:0] av;
    logic [7:0] bv;
    logic [5:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Word-order model: walk from the left end of each word.
  function automatic logic ref_less(logic [7:0] x, int lx, logic [7:0] y, int ly);
    int n = (lx < ly) ? lx : ly;
    for (int i = 0; i < n; i++) begin
      if (x[lx-1-i] != y[ly-1-i]) return (y[ly-1-i] == 1'b1);
    end
    return (lx < ly);
  endfunction

  function automatic logic [5:0] ref_flags(logic [7:0] x, int lx, logic [7:0] y, int ly);
    logic l, g, e;
    l = ref_less(x, lx, y, ly);
    g = ref_less(y, ly, x, lx);
    e = (lx == ly) && !l && !g;
    return {e, !e, l, !g, g, !l};
  endfunction

  task automatic check_bit(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, got, exp);
    end
  endtask

  task automatic push(int id, logic [7:0] av, int la, logic [7:0] bv, int lb);
    item_t it;
    it.id = id; it.av = av; it.bv = bv;
    it.exp = ref_flags(av, la, bv, lb);
    q.push_back(it);
  endtask

  // Driver: apply all three copies at once and queue expectations.
  task automatic drive(logic [7:0] v);
    a0 = v[7:3]; b0 = v[2:0];
    a1 = v[7:4]; b1 = v[3:0];
    a2 = v[7:6]; b2 = v[5:0];
    push(0, {3'b0, v[7:3]}, A0, {5'b0, v[2:0]}, B0);
    push(1, {4'b0, v[7:4]}, A1, {4'b0, v[3:0]}, B1);
    push(2, {6'b0, v[7:6]}, A2, {2'b0, v[5:0]}, B2);
  endtask

  // Monitor: outputs are combinational, sample at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [5:0] got;
      string ctx;
      it  = q.pop_front();
      got = (it.id == 0) ? f0 : (it.id == 1) ? f1 : f2;
      ctx = $sformatf("u%0d a=%b b=%b", it.id, it.av, it.bv);
      check_bit((it.id == 1) ? "R5" : "R4", {ctx, " eq"}, got[5], it.exp[5]);
      check_bit("R5", {ctx, " ne"}, got[4], it.exp[4]);
      check_bit("R2", {ctx, " lt"}, got[3], it.exp[3]);
      check_bit("R7", {ctx, " le"}, got[2], it.exp[2]);
      check_bit("R6", {ctx, " gt"}, got[1], it.exp[1]);
      check_bit("R7", {ctx, " ge"}, got[0], it.exp[0]);
      check_bit("R8", {ctx, " one-of"}, logic'($countones({got[5], got[3], got[1]}) == 1), 1'b1);
    end
  end

  initial begin
    // Idle state: all inputs zero.
    @(negedge clk);
    check_bit("R9", "u1 zeros eq", f1[5], 1'b1);
    check_bit("R9", "u1 zeros lt", f1[3], 1'b0);
    check_bit("R9", "u1 zeros gt", f1[1], 1'b0);
    check_bit("R4", "u0 zeros eq", f0[5], 1'b0);
    check_bit("R3", "u0 zeros gt", f0[1], 1'b1);
    check_bit("R3", "u2 zeros lt", f2[3], 1'b1);

    // Exhaustive sweep of every pair for every copy.
    for (int i = 0; i < 256; i++) begin
      @(posedge clk);
      drive(i[7:0]);
    end
    @(negedge clk);
    @(negedge clk);

    // R1: leftmost pair dominates lower bits.
    @(posedge clk);
    a1 = 4'b1000; b1 = 4'b0111;
    @(negedge clk);
    check_bit("R1", "u1 1000 vs 0111 gt", f1[1], 1'b1);
    check_bit("R1", "u1 1000 vs 0111 lt", f1[3], 1'b0);

    // R3: prefix match, trailing bits of longer a vary.
    @(posedge clk);
    a0 = 5'b10111; b0 = 3'b101;
    @(negedge clk);
    check_bit("R3", "u0 10111 vs 101 gt", f0[1], 1'b1);
    @(posedge clk);
    a0 = 5'b10100;
    @(negedge clk);
    check_bit("R3", "u0 10100 vs 101 gt", f0[1], 1'b1);
    check_bit("R3", "u0 10100 vs 101 lt", f0[3], 1'b0);

    // R3: shorter a is prefix of longer b.
    @(posedge clk);
    a2 = 2'b11; b2 = 6'b110000;
    @(negedge clk);
    check_bit("R3", "u2 11 vs 110000 lt", f2[3], 1'b1);
    @(posedge clk);
    b2 = 6'b111111;
    @(negedge clk);
    check_bit("R3", "u2 11 vs 111111 lt", f2[3], 1'b1);
    check_bit("R2", "u2 11 vs 111111 ge", f2[0], 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule